// File: doc/BRIEF.md
# Partial Reconfiguration Handshake Sequencer

This block runs the control handshake that prepares a device region for partial reconfiguration, lets image data stream into it, and closes the session again. A start command is accepted only when the mode-select input selects a passive-parallel mode and both configuration pins read high. The sequencer then selects the target, opens the configuration data and clock path, takes over the configuration lines, and has an external generator flush the interface with clock bursts. It then raises the reconfiguration request, has the generator send a preamble burst, and polls for the ready flag.

Once the target reports ready, the sequencer holds in a streaming phase until a finish command arrives. It then polls for the done flag and tears the session down in a fixed order. The teardown runs whatever the outcome of the polls, and a single result pulse carries an error code afterwards. A registered status summary reports what the target is doing from its status flags, with no dependence on the sequence state.

Top module: `prc_handshake_seq`

## Requirements
- R1: After reset: `ncs_o`=1, `ovr_en_o`=0, `cfg_en_o`=0, `pr_req_o`=0, `burst_req_o`=0, `stream_o`=0, `busy_o`=0, `done_o`=0, `err_code_o`=0, `wide_o`=1 (1 means 32-bit width, 0 means 16-bit).
- R2: A start with `msel_i` other than 0 or 1 is rejected: one cycle later `done_o` pulses with `err_code_o`=1, and no control output changes. The mode is checked before the pins, so a bad mode with bad pins also gives code 1.
- R3: A start with a legal mode but `ncfg_pin_i` or `nstat_pin_i` low is rejected the same way, with `err_code_o`=2.
- R4: An accepted start sets `ncs_o`=0, `wide_o`=0 and `ratio_o` at the accepting edge. It sets `cfg_en_o`=1 one cycle later. One cycle after that it sets `ovr_en_o`=1 and requests a burst of FLUSH_LEN (256) clocks. When that burst completes, `pr_req_o` rises one cycle after `burst_req_o` falls, together with a request for a burst of PRE_LEN (2047) clocks.
- R5: `ratio_o` is 2 (divide by four) if `cmp_i` is high, otherwise 1 (divide by two) if `enc_i` is high, otherwise 0 (divide by one).
- R6: After the preamble, `ready_i` and `err_i` are sampled once per cycle for at most POLLS (10) cycles. `err_i` wins and ends the wait with code 3. `ready_i` raises `stream_o` one cycle later. Ten samples without either give code 4. Both failures go straight to teardown.
- R7: `stream_o` stays high until `finish_i`, and falls one cycle after it.
- R8: The done wait samples `done_i`/`err_i` the same way as R6 (POLLS samples, error first). Teardown then runs in this order: drop `pr_req_o` with a FLUSH_LEN burst request; one cycle after the burst completes, `cfg_en_o`=0; one cycle later `ncs_o`=1; one cycle later `ovr_en_o`=0; one cycle later `done_o` pulses.
- R9: The teardown of R8 also runs after any failed ready or done wait, and the error code from that wait (3 or 4) is reported only in the final pulse.
- R10: If no earlier error occurred, the final pulse carries code 0 when `usermode_i`, `confdone_i` and `nstat_pin_i` are all high at the final step, and code 4 otherwise. `done_o` is never high two cycles in a row.
- R11: `stat_o` is registered, one cycle behind its inputs. It is 4 (operating) if `usermode_i` is high, else 3 (writing) if `ready_i` is high, else 2 (error) if `crc_err_i` is high, else 1 (held in reset) if `nstat_pin_i` is low, else 0.
- R12: `start_i` has no effect while `busy_o` is high.
- R13: `burst_req_o` and `burst_len_o` are held until `burst_done_i` is seen, and `burst_req_o` falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command (one cycle) |
| finish_i | input | 1 | Data streaming finished (one cycle) |
| enc_i | input | 1 | Image is encrypted |
| cmp_i | input | 1 | Image is compressed |
| msel_i | input | MSEL_W | Mode-select pins |
| ncfg_pin_i | input | 1 | Configuration pin level (active low) |
| nstat_pin_i | input | 1 | Status pin level (active low) |
| ready_i | input | 1 | Target ready for reconfiguration data |
| done_i | input | 1 | Target reports reconfiguration done |
| err_i | input | 1 | Target reports reconfiguration error |
| usermode_i | input | 1 | Target in user mode |
| confdone_i | input | 1 | Configuration-done pin level |
| crc_err_i | input | 1 | Target CRC error flag |
| burst_done_i | input | 1 | Clock burst finished (one cycle) |
| ncs_o | output | 1 | Chip select, active low |
| ovr_en_o | output | 1 | Configuration line override enabled |
| cfg_en_o | output | 1 | Configuration data and clock path enabled |
| pr_req_o | output | 1 | Reconfiguration request |
| wide_o | output | 1 | Data width: 1 = 32 bit, 0 = 16 bit |
| ratio_o | output | 2 | Clock-to-data ratio code |
| burst_req_o | output | 1 | Clock burst request |
| burst_len_o | output | LEN_W | Clock count of the requested burst |
| stream_o | output | 1 | Data may be streamed |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | Result pulse |
| err_code_o | output | 3 | 0 ok, 1 bad mode, 2 pin conflict, 3 protocol error, 4 timeout |
| stat_o | output | 3 | Status summary code |

## Verification
The assertions assume that the clock generator raises `burst_done_i` only while `burst_req_o` is high, and only for one cycle. They also assume that `start_i` and `finish_i` are single-cycle pulses. The bench plays the clock generator itself. It answers each request after a random delay of zero to three cycles with a single done pulse, and drives `finish_i` only while `stream_o` is high. It places the ready, done and error flags at chosen sample indices, both inside and outside the ten-sample window.

// File: rtl/prc_pkg.sv
package prc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PATH_ON, ST_OVR_ON, ST_FLUSH_A, ST_REQ_ON, ST_PREAMBLE,
    ST_WAIT_RDY, ST_STREAM, ST_WAIT_DONE, ST_REQ_OFF, ST_FLUSH_B,
    ST_PATH_OFF, ST_CS_OFF, ST_OVR_OFF, ST_VERDICT
  } seq_state_t;

  typedef enum logic [2:0] {
    EC_NONE = 3'd0, EC_MODE = 3'd1, EC_PINS = 3'd2,
    EC_PROTO = 3'd3, EC_TIMEOUT = 3'd4
  } err_code_t;

  typedef enum logic [2:0] {
    SS_UNKNOWN = 3'd0, SS_RESET = 3'd1, SS_ERROR = 3'd2,
    SS_WRITING = 3'd3, SS_OPERATING = 3'd4
  } summary_t;

  // Clock-to-data ratio code for a 16-bit data path.
  function automatic logic [1:0] ratio_pick(input logic enc, input logic cmp);
    if (cmp)      return 2'd2;
    else if (enc) return 2'd1;
    else          return 2'd0;
  endfunction

endpackage

// File: rtl/prc_poll_window.sv
module prc_poll_window #(
  parameter int POLLS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  output logic last_o
);
  localparam int POLL_W = $clog2(POLLS + 1);

  logic [POLL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt <= '0;
    else if (tick_i)  cnt <= cnt + POLL_W'(1);
  end

  assign last_o = (cnt == POLL_W'(POLLS - 1));
endmodule

// File: rtl/prc_stat_summary.sv
module prc_stat_summary
  import prc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       usermode_i,
  input  logic       ready_i,
  input  logic       crc_err_i,
  input  logic       nstat_pin_i,
  output logic [2:0] stat_o
);
  summary_t nxt;

  always_comb begin
    if (usermode_i)        nxt = SS_OPERATING;
    else if (ready_i)      nxt = SS_WRITING;
    else if (crc_err_i)    nxt = SS_ERROR;
    else if (!nstat_pin_i) nxt = SS_RESET;
    else                   nxt = SS_UNKNOWN;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_o <= SS_UNKNOWN;
    else     stat_o <= nxt;
  end
endmodule

// File: rtl/prc_seq_ctrl.sv
module prc_seq_ctrl
  import prc_pkg::*;
#(
  parameter int MSEL_W    = 3,
  parameter int LEN_W     = 12,
  parameter int FLUSH_LEN = 256,
  parameter int PRE_LEN   = 2047
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              finish_i,
  input  logic              enc_i,
  input  logic              cmp_i,
  input  logic [MSEL_W-1:0] msel_i,
  input  logic              ncfg_pin_i,
  input  logic              nstat_pin_i,
  input  logic              ready_i,
  input  logic              done_i,
  input  logic              err_i,
  input  logic              usermode_i,
  input  logic              confdone_i,
  input  logic              burst_done_i,
  input  logic              poll_last_i,
  output logic              poll_tick_o,
  output logic              poll_clr_o,
  output logic              ncs_o,
  output logic              ovr_en_o,
  output logic              cfg_en_o,
  output logic              pr_req_o,
  output logic              wide_o,
  output logic [1:0]        ratio_o,
  output logic              burst_req_o,
  output logic [LEN_W-1:0]  burst_len_o,
  output logic              stream_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        err_code_o
);
  seq_state_t state;
  err_code_t  pend;

  assign poll_tick_o = (state == ST_WAIT_RDY) || (state == ST_WAIT_DONE);
  assign poll_clr_o  = !poll_tick_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pend        <= EC_NONE;
      ncs_o       <= 1'b1;
      ovr_en_o    <= 1'b0;
      cfg_en_o    <= 1'b0;
      pr_req_o    <= 1'b0;
      wide_o      <= 1'b1;
      ratio_o     <= 2'd0;
      burst_req_o <= 1'b0;
      burst_len_o <= '0;
      stream_o    <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      err_code_o  <= EC_NONE;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          if (msel_i > MSEL_W'(1)) begin
            done_o     <= 1'b1;
            err_code_o <= EC_MODE;
          end else if (!(ncfg_pin_i && nstat_pin_i)) begin
            done_o     <= 1'b1;
            err_code_o <= EC_PINS;
          end else begin
            ncs_o   <= 1'b0;
            wide_o  <= 1'b0;
            ratio_o <= ratio_pick(enc_i, cmp_i);
            busy_o  <= 1'b1;
            pend    <= EC_NONE;
            state   <= ST_PATH_ON;
          end
        end
        ST_PATH_ON: begin
          cfg_en_o <= 1'b1;
          state    <= ST_OVR_ON;
        end
        ST_OVR_ON: begin
          ovr_en_o    <= 1'b1;
          burst_req_o <= 1'b1;
          burst_len_o <= LEN_W'(FLUSH_LEN);
          state       <= ST_FLUSH_A;
        end
        ST_FLUSH_A: if (burst_done_i) begin
          burst_req_o <= 1'b0;
          state       <= ST_REQ_ON;
        end
        ST_REQ_ON: begin
          pr_req_o    <= 1'b1;
          burst_req_o <= 1'b1;
          burst_len_o <= LEN_W'(PRE_LEN);
          state       <= ST_PREAMBLE;
        end
        ST_PREAMBLE: if (burst_done_i) begin
          burst_req_o <= 1'b0;
          state       <= ST_WAIT_RDY;
        end
        ST_WAIT_RDY: begin
          if (err_i) begin
            pend  <= EC_PROTO;
            state <= ST_REQ_OFF;
          end else if (ready_i) begin
            stream_o <= 1'b1;
            state    <= ST_STREAM;
          end else if (poll_last_i) begin
            pend  <= EC_TIMEOUT;
            state <= ST_REQ_OFF;
          end
        end
        ST_STREAM: if (finish_i) begin
          stream_o <= 1'b0;
          state    <= ST_WAIT_DONE;
        end
        ST_WAIT_DONE: begin
          if (err_i) begin
            pend  <= EC_PROTO;
            state <= ST_REQ_OFF;
          end else if (done_i) begin
            state <= ST_REQ_OFF;
          end else if (poll_last_i) begin
            pend  <= EC_TIMEOUT;
            state <= ST_REQ_OFF;
          end
        end
        ST_REQ_OFF: begin
          pr_req_o    <= 1'b0;
          burst_req_o <= 1'b1;
          burst_len_o <= LEN_W'(FLUSH_LEN);
          state       <= ST_FLUSH_B;
        end
        ST_FLUSH_B: if (burst_done_i) begin
          burst_req_o <= 1'b0;
          state       <= ST_PATH_OFF;
        end
        ST_PATH_OFF: begin
          cfg_en_o <= 1'b0;
          state    <= ST_CS_OFF;
        end
        ST_CS_OFF: begin
          ncs_o <= 1'b1;
          state <= ST_OVR_OFF;
        end
        ST_OVR_OFF: begin
          ovr_en_o <= 1'b0;
          state    <= ST_VERDICT;
        end
        ST_VERDICT: begin
          done_o <= 1'b1;
          busy_o <= 1'b0;
          if (pend != EC_NONE)
            err_code_o <= pend;
          else if (usermode_i && confdone_i && nstat_pin_i)
            err_code_o <= EC_NONE;
          else
            err_code_o <= EC_TIMEOUT;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prc_handshake_seq.sv
module prc_handshake_seq
  import prc_pkg::*;
#(
  parameter int MSEL_W    = 3,
  parameter int LEN_W     = 12,
  parameter int FLUSH_LEN = 256,
  parameter int PRE_LEN   = 2047,
  parameter int POLLS     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              finish_i,
  input  logic              enc_i,
  input  logic              cmp_i,
  input  logic [MSEL_W-1:0] msel_i,
  input  logic              ncfg_pin_i,
  input  logic              nstat_pin_i,
  input  logic              ready_i,
  input  logic              done_i,
  input  logic              err_i,
  input  logic              usermode_i,
  input  logic              confdone_i,
  input  logic              crc_err_i,
  input  logic              burst_done_i,
  output logic              ncs_o,
  output logic              ovr_en_o,
  output logic              cfg_en_o,
  output logic              pr_req_o,
  output logic              wide_o,
  output logic [1:0]        ratio_o,
  output logic              burst_req_o,
  output logic [LEN_W-1:0]  burst_len_o,
  output logic              stream_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        err_code_o,
  output logic [2:0]        stat_o
);
  logic poll_tick, poll_clr, poll_last;

  prc_poll_window #(.POLLS(POLLS)) u_poll (
    .clk(clk), .rst(rst), .clr_i(poll_clr), .tick_i(poll_tick),
    .last_o(poll_last)
  );

  prc_seq_ctrl #(
    .MSEL_W(MSEL_W), .LEN_W(LEN_W), .FLUSH_LEN(FLUSH_LEN), .PRE_LEN(PRE_LEN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .finish_i(finish_i),
    .enc_i(enc_i), .cmp_i(cmp_i), .msel_i(msel_i),
    .ncfg_pin_i(ncfg_pin_i), .nstat_pin_i(nstat_pin_i),
    .ready_i(ready_i), .done_i(done_i), .err_i(err_i),
    .usermode_i(usermode_i), .confdone_i(confdone_i),
    .burst_done_i(burst_done_i), .poll_last_i(poll_last),
    .poll_tick_o(poll_tick), .poll_clr_o(poll_clr),
    .ncs_o(ncs_o), .ovr_en_o(ovr_en_o), .cfg_en_o(cfg_en_o),
    .pr_req_o(pr_req_o), .wide_o(wide_o), .ratio_o(ratio_o),
    .burst_req_o(burst_req_o), .burst_len_o(burst_len_o),
    .stream_o(stream_o), .busy_o(busy_o), .done_o(done_o),
    .err_code_o(err_code_o)
  );

  prc_stat_summary u_sum (
    .clk(clk), .rst(rst), .usermode_i(usermode_i), .ready_i(ready_i),
    .crc_err_i(crc_err_i), .nstat_pin_i(nstat_pin_i), .stat_o(stat_o)
  );
endmodule

// File: rtl/prc_handshake_seq_chk.sv
module prc_handshake_seq_chk #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             burst_done_i,
  input logic             ncs_o,
  input logic             ovr_en_o,
  input logic             cfg_en_o,
  input logic             pr_req_o,
  input logic             burst_req_o,
  input logic [LEN_W-1:0] burst_len_o,
  input logic             stream_o,
  input logic             busy_o,
  input logic             done_o
);
  // R1: outside a session the target is released
  p_idle_released_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (ncs_o && !ovr_en_o && !cfg_en_o && !pr_req_o && !burst_req_o));

  // R4: a burst is only requested with the target selected and taken over
  p_burst_setup_r4: assert property (@(posedge clk) disable iff (rst)
    burst_req_o |-> (!ncs_o && ovr_en_o && cfg_en_o));

  // R8: the request never outlives the data path
  p_req_inside_path_r8: assert property (@(posedge clk) disable iff (rst)
    pr_req_o |-> (cfg_en_o && !ncs_o));

  // R7: streaming only under an active request
  p_stream_req_r7: assert property (@(posedge clk) disable iff (rst)
    stream_o |-> pr_req_o);

  // R13: request and length hold until the generator answers
  p_burst_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (burst_req_o && !burst_done_i) |=> (burst_req_o && $stable(burst_len_o)));

  // R13: request drops right after completion
  p_burst_drop_r13: assert property (@(posedge clk) disable iff (rst)
    (burst_req_o && burst_done_i) |=> !burst_req_o);

  // R10: result is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: a session always ends with a result pulse
  p_end_reports_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
endmodule

bind prc_handshake_seq prc_handshake_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .burst_done_i(burst_done_i), .ncs_o(ncs_o),
  .ovr_en_o(ovr_en_o), .cfg_en_o(cfg_en_o), .pr_req_o(pr_req_o),
  .burst_req_o(burst_req_o), .burst_len_o(burst_len_o),
  .stream_o(stream_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/prc_handshake_seq_bench.sv
`timescale 1ns/1ps
module prc_handshake_seq_bench;
  localparam int LEN_W = 12;
  localparam int POLLS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, finish_i = 0, enc_i = 0, cmp_i = 0;
  logic [2:0] msel_i = 0;
  logic ncfg_pin_i = 1, nstat_pin_i = 1, ready_i = 0, done_i = 0, err_i = 0;
  logic usermode_i = 0, confdone_i = 0, crc_err_i = 0, burst_done_i = 0;
  logic ncs_o, ovr_en_o, cfg_en_o, pr_req_o, wide_o, burst_req_o;
  logic stream_o, busy_o, done_o;
  logic [1:0] ratio_o;
  logic [LEN_W-1:0] burst_len_o;
  logic [2:0] err_code_o, stat_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  prc_handshake_seq u_prc_handshake_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .finish_i(finish_i),
    .enc_i(enc_i), .cmp_i(cmp_i), .msel_i(msel_i),
    .ncfg_pin_i(ncfg_pin_i), .nstat_pin_i(nstat_pin_i),
    .ready_i(ready_i), .done_i(done_i), .err_i(err_i),
    .usermode_i(usermode_i), .confdone_i(confdone_i), .crc_err_i(crc_err_i),
    .burst_done_i(burst_done_i), .ncs_o(ncs_o), .ovr_en_o(ovr_en_o),
    .cfg_en_o(cfg_en_o), .pr_req_o(pr_req_o), .wide_o(wide_o),
    .ratio_o(ratio_o), .burst_req_o(burst_req_o), .burst_len_o(burst_len_o),
    .stream_o(stream_o), .busy_o(busy_o), .done_o(done_o),
    .err_code_o(err_code_o), .stat_o(stat_o)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int exp_ratio(input logic enc, input logic cmp);
    return cmp ? 2 : (enc ? 1 : 0);
  endfunction

  function automatic int exp_stat(input logic um, input logic rdy,
                                  input logic crc, input logic ns);
    if (um) return 4;
    if (rdy) return 3;
    if (crc) return 2;
    if (!ns) return 1;
    return 0;
  endfunction

  function automatic int exp_code(input int rdy_at, input logic rdy_err,
                                  input int dn_at, input logic dn_err,
                                  input logic um, input logic cd, input logic ns);
    if (rdy_at >= POLLS) return 4;
    if (rdy_err) return 3;
    if (dn_at >= POLLS) return 4;
    if (dn_err) return 3;
    return (um && cd && ns) ? 0 : 4;
  endfunction

  task automatic wait_burst();
    for (int k = 0; k < 40 && !burst_req_o; k++) step();
  endtask

  // Plays the clock generator: answers after dly cycles with one done pulse.
  task automatic burst_serve(input int len, input int dly, input string tag);
    wait_burst();
    check({tag, " R13 burst requested"}, burst_req_o, 1);
    check({tag, " R4 burst length"}, burst_len_o, len);
    for (int k = 0; k < dly; k++) begin
      step();
      check({tag, " R13 request held"}, burst_req_o, 1);
      check({tag, " R13 length held"}, burst_len_o, len);
    end
    burst_done_i = 1;
    step();
    burst_done_i = 0;
    check({tag, " R13 request dropped"}, burst_req_o, 0);
  endtask

  task automatic reject_run(input logic [2:0] msel, input logic ncfg,
                            input logic nst, input int code, input string tag);
    msel_i = msel; ncfg_pin_i = ncfg; nstat_pin_i = nst; start_i = 1;
    step();
    start_i = 0;
    check({tag, " result pulse"}, done_o, 1);
    check({tag, " error code"}, err_code_o, code);
    check({tag, " target untouched"}, {ncs_o, cfg_en_o, ovr_en_o, busy_o},
          4'b1000);
    step();
    check({tag, " R10 single pulse"}, done_o, 0);
    msel_i = 0; ncfg_pin_i = 1; nstat_pin_i = 1;
  endtask

  task automatic full_run(input logic enc, input logic cmp, input int rdy_at,
                          input logic rdy_err, input int dn_at, input logic dn_err,
                          input logic um, input logic cd, input logic ns,
                          input int dly);
    int lim;
    int code;
    code = exp_code(rdy_at, rdy_err, dn_at, dn_err, um, cd, ns);
    enc_i = enc; cmp_i = cmp; msel_i = 3'($urandom_range(0, 1)); start_i = 1;
    step();
    start_i = 0;
    check("R4 chip select at accept", ncs_o, 0);
    check("R4 width 16 at accept", wide_o, 0);
    check("R5 ratio", ratio_o, exp_ratio(enc, cmp));
    check("R4 path not yet on", cfg_en_o, 0);
    step();
    check("R4 path on", cfg_en_o, 1);
    check("R4 override not yet on", ovr_en_o, 0);
    step();
    check("R4 override on", ovr_en_o, 1);
    check("R4 flush requested with override", burst_req_o, 1);
    start_i = 1; msel_i = 3'd7;  // R12: must be ignored while busy
    step();
    start_i = 0; msel_i = 0;
    check("R12 start ignored during flush", done_o, 0);
    burst_serve(256, dly, "flush-a");
    check("R4 request waits for flush", pr_req_o, 0);
    step();
    check("R4 request raised", pr_req_o, 1);
    burst_serve(2047, dly, "preamble");
    lim = (rdy_at < POLLS) ? rdy_at : POLLS - 1;
    for (int i = 0; i <= lim; i++) begin
      ready_i = (i >= rdy_at);
      err_i = rdy_err && (i >= rdy_at);
      if (i == lim) check("R6 no early ready", stream_o, 0);
      step();
    end
    ready_i = 0; err_i = 0;
    check("R6 ready wait outcome", stream_o, (rdy_at < POLLS) && !rdy_err);
    if (stream_o) begin
      for (int k = 0; k < dly; k++) begin
        if (k == 0) start_i = 1;
        step();
        start_i = 0;
        check("R7 stream held", stream_o, 1);
        check("R12 start ignored while streaming", ncs_o, 0);
      end
      finish_i = 1;
      step();
      finish_i = 0;
      check("R7 stream falls after finish", stream_o, 0);
      lim = (dn_at < POLLS) ? dn_at : POLLS - 1;
      for (int i = 0; i <= lim; i++) begin
        done_i = (i >= dn_at);
        err_i = dn_err && (i >= dn_at);
        step();
      end
      done_i = 0; err_i = 0;
    end
    usermode_i = um; confdone_i = cd; nstat_pin_i = ns;
    wait_burst();
    check("R8 request dropped before flush", pr_req_o, 0);
    check("R9 path still on during flush", cfg_en_o, 1);
    burst_serve(256, dly, "flush-b");
    check("R8 path on right after flush", cfg_en_o, 1);
    step();
    check("R8 path off", cfg_en_o, 0);
    check("R8 still selected", ncs_o, 0);
    step();
    check("R8 deselected", ncs_o, 1);
    check("R8 override still on", ovr_en_o, 1);
    step();
    check("R8 override off", ovr_en_o, 0);
    check("R9 no early result", done_o, 0);
    step();
    check("R9 result pulse", done_o, 1);
    check("R10 final code", err_code_o, code);
    check("R9 idle after result", busy_o, 0);
    step();
    check("R10 single pulse", done_o, 0);
    usermode_i = 0; confdone_i = 0; nstat_pin_i = 1;
  endtask

  task automatic summary_case(input logic um, input logic rdy, input logic crc,
                              input logic ns);
    usermode_i = um; ready_i = rdy; crc_err_i = crc; nstat_pin_i = ns;
    step();
    check("R11 status summary", stat_o, exp_stat(um, rdy, crc, ns));
    usermode_i = 0; ready_i = 0; crc_err_i = 0; nstat_pin_i = 1;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R13 watchdog: actual=hung expected=progress");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    repeat (3) step();
    rst = 0;
    step();
    check("R1 chip select idle", ncs_o, 1);
    check("R1 controls idle", {ovr_en_o, cfg_en_o, pr_req_o, burst_req_o}, 0);
    check("R1 session flags idle", {stream_o, busy_o, done_o}, 0);
    check("R1 error code", err_code_o, 0);
    check("R1 wide after reset", wide_o, 1);

    for (int m = 2; m < 8; m++) reject_run(3'(m), 1, 1, 1, "R2 bad mode");
    reject_run(3'd5, 0, 0, 1, "R2 mode before pins");
    reject_run(3'd0, 0, 1, 2, "R3 config pin low");
    reject_run(3'd1, 1, 0, 2, "R3 status pin low");
    reject_run(3'd0, 0, 0, 2, "R3 both pins low");

    summary_case(1, 1, 1, 0);
    summary_case(0, 1, 1, 0);
    summary_case(0, 0, 1, 0);
    summary_case(0, 0, 0, 0);
    summary_case(0, 0, 0, 1);

    // Directed corners: first sample, last sample, one past the window.
    full_run(0, 0, 0, 0, 0, 0, 1, 1, 1, 0);
    full_run(1, 0, 9, 0, 9, 0, 1, 1, 1, 1);
    full_run(0, 1, 10, 0, 0, 0, 1, 1, 1, 0);
    full_run(1, 1, 3, 1, 0, 0, 1, 1, 1, 2);
    full_run(0, 0, 2, 0, 10, 0, 1, 1, 1, 1);
    full_run(1, 0, 1, 0, 4, 1, 1, 1, 1, 0);
    full_run(0, 0, 1, 0, 1, 0, 1, 0, 1, 3);

    for (int r = 0; r < 24; r++) begin
      logic e, c, re, de, um, cd, ns;
      int ra, da;
      e = 1'($urandom_range(0, 1));
      c = 1'($urandom_range(0, 1));
      ra = $urandom_range(0, 11);
      re = ($urandom_range(0, 4) == 0);
      da = $urandom_range(0, 11);
      de = ($urandom_range(0, 4) == 0);
      um = ($urandom_range(0, 5) != 0);
      cd = ($urandom_range(0, 5) != 0);
      ns = ($urandom_range(0, 5) != 0);
      full_run(e, c, ra, re, da, de, um, cd, ns, $urandom_range(0, 3));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule